// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two up-counters, timer 0 and timer 1. Each has a low byte and a high byte, and the two share a configuration byte and a control byte, all reached over a byte-wide register bus with a one-cycle write strobe and a combinational read port.

Each counter steps on one of two sources: a tick that the block makes once every twelve core clocks, or a falling edge on its own external count pin, which is synchronised first. The timer's run bit enables counting. When the gate option is on, the synchronised gate pin must also be high.

Every configuration nibble picks one of four modes:
- a 13-bit count,
- a 16-bit count,
- an 8-bit count that reloads from the high byte,
- a split mode. In split mode timer 0 becomes two independent 8-bit counters, and timer 1 simply holds.

On overflow a counter sets its flag. Each flag drives an interrupt request output directly. Software clears a flag by writing 0 to it.

When timer 0 is in split mode, its high byte takes over timer 1's run bit and flag. Timer 1 may keep counting in its own mode, but its overflow then sets no flag. A bus write to a count byte takes precedence over counting in the same cycle. A hardware flag set takes precedence over a bus write that clears it in the same cycle.

Top module: `tc_pair`

## Requirements
- R1: After reset, all six registers read 0x00 and both interrupt outputs are low.
- R2: The register map is as follows:
  - control at 0x88: bit 7 = flag 1, bit 6 = run 1, bit 5 = flag 0, bit 4 = run 0; bits 3:0 read 0.
  - configuration at 0x89: bits 7:4 configure timer 1 and bits 3:0 configure timer 0, each nibble as {gate, external select, mode[1:0]}.
  - timer 0 low byte at 0x8A, timer 1 low byte at 0x8B, timer 0 high byte at 0x8C, timer 1 high byte at 0x8D.
  - every written value reads back, and unmapped addresses read 0x00.
- R3: With external select 0, a running counter advances by exactly k in any window of 12·k consecutive clocks.
- R4: Mode 1 counts {high, low} as 16 bits. Rolling from 0xFFFF to 0x0000 sets the timer's flag, and the flag shows on the interrupt output.
- R5: Mode 0 counts {high, low[4:0]} as 13 bits. Bits 7:5 of the low byte keep their written value. Rolling from 0x1FFF to 0 sets the flag.
- R6: Mode 2 counts only the low byte. A step from 0xFF loads the high byte into the low byte and sets the flag. The high byte is unchanged.
- R7: With the gate option set, a running counter does not count while its gate pin is low, and counts normally while it is high.
- R8: With external select 1, each 1-to-0 transition of the count pin advances the count by one. Rising edges and the internal tick do not advance it.
- R9: Writing 0 to a flag bit clears that flag and its interrupt output.
- R10: With timer 0 in mode 3, the low byte counts as an 8-bit counter under run 0 and sets flag 0 on wrap. The high byte counts internal ticks under run 1 and sets flag 1 on wrap.
- R11: With timer 1 in mode 3, its count bytes hold even while run 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cnt_pin | input | 2 | External count pins, index = timer |
| gate_pin | input | 2 | Gate pins, index = timer |
| irq | output | 2 | Overflow interrupt requests, index = timer |

## Verification
The divide-by-twelve tick runs freely from reset, so its phase is not visible at the ports. The stimulus therefore opens and closes each counting window with control-register writes spaced exactly 12·k clock edges apart. Such a window holds exactly k ticks whatever the phase.

The stop write copies back the flag bits it reads just before the closing edge. An overflow on that last counted edge is therefore still seen, through the rule that a hardware set wins.

Split mode is the hardest case to reach. Both halves of timer 0 must be loaded just below their wrap points, in one shared window, so that both flags rise together.

// File: rtl/tc_pair_pkg.sv
package tc_pair_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_TMR  = 2;
  localparam int PRE_DIV  = 12;
  localparam int LOW_BITS = 5;

  localparam logic [BYTE_W-1:0] ADDR_CTRL = 8'h88;
  localparam logic [BYTE_W-1:0] ADDR_CFG  = 8'h89;
  localparam logic [BYTE_W-1:0] ADDR_LO0  = 8'h8A;
  localparam logic [BYTE_W-1:0] ADDR_LO1  = 8'h8B;
  localparam logic [BYTE_W-1:0] ADDR_HI0  = 8'h8C;
  localparam logic [BYTE_W-1:0] ADDR_HI1  = 8'h8D;

  typedef enum logic [1:0] {
    MODE_13B    = 2'd0,
    MODE_16B    = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tc_mode_e;

  typedef struct packed {
    logic     gate_en;
    logic     ext_sel;
    tc_mode_e mode;
  } tc_cfg_t;
endpackage

// File: rtl/tc_prescale.sv
module tc_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tc_pin_sync.sv
module tc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;
  logic              prev_q;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], pin_in};
  end

  assign level = sr_q[STAGES-1];
  assign fall  = prev_q & ~level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      prev_q <= level;
    end
  end
endmodule

// File: rtl/tc_step.sv
module tc_step
  import tc_pair_pkg::*;
#(
  parameter int W  = 8,
  parameter int LB = 5
) (
  input  tc_mode_e     mode,
  input  logic         inc,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] lo_n,
  output logic [W-1:0] hi_n,
  output logic         wrap
);
  localparam int PW = W + LB;
  localparam int FW = 2 * W;

  logic [PW-1:0] p_cur;
  logic [PW-1:0] p_inc;
  logic [FW-1:0] f_cur;
  logic [FW-1:0] f_inc;
  logic [W-1:0]  lo_inc;

  assign p_cur  = {hi, lo[LB-1:0]};
  assign p_inc  = p_cur + PW'(1);
  assign f_cur  = {hi, lo};
  assign f_inc  = f_cur + FW'(1);
  assign lo_inc = lo + W'(1);

  always_comb begin
    lo_n = lo;
    hi_n = hi;
    wrap = 1'b0;
    if (inc) begin
      unique case (mode)
        MODE_13B: begin
          lo_n = {lo[W-1:LB], p_inc[LB-1:0]};
          hi_n = p_inc[PW-1:LB];
          wrap = &p_cur;
        end
        MODE_16B: begin
          lo_n = f_inc[W-1:0];
          hi_n = f_inc[FW-1:W];
          wrap = &f_cur;
        end
        MODE_RELOAD: begin
          lo_n = (&lo) ? hi : lo_inc;
          wrap = &lo;
        end
        default: begin
          lo_n = lo_inc;
          wrap = &lo;
        end
      endcase
    end
  end
endmodule

// File: rtl/tc_pair.sv
module tc_pair
  import tc_pair_pkg::*;
#(
  parameter int DIV         = PRE_DIV,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [BYTE_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [NUM_TMR-1:0] cnt_pin,
  input  logic [NUM_TMR-1:0] gate_pin,
  output logic [NUM_TMR-1:0] irq
);
  localparam int NIB = BYTE_W / 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sr_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr_q <= 2'b00;
    else        rst_sr_q <= {rst_sr_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sr_q[1];

  logic [BYTE_W-1:0]  lo_q [NUM_TMR];
  logic [BYTE_W-1:0]  hi_q [NUM_TMR];
  logic [BYTE_W-1:0]  lo_d [NUM_TMR];
  logic [BYTE_W-1:0]  hi_d [NUM_TMR];
  logic [BYTE_W-1:0]  lo_n [NUM_TMR];
  logic [BYTE_W-1:0]  hi_n [NUM_TMR];
  logic [BYTE_W-1:0]  cfg_q, cfg_d;
  logic [NUM_TMR-1:0] run_q, run_d, flag_q, flag_d;
  logic [NUM_TMR-1:0] gate_lvl, pin_fall, cnt_en, inc, wrap, set;
  tc_cfg_t            cfg [NUM_TMR];
  logic               tick, split;
  logic               hi_split_inc, hi_split_wrap;
  logic [BYTE_W-1:0]  hi_split_n;

  tc_prescale #(.DIV(DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick)
  );

  assign split = (cfg[0].mode == MODE_SPLIT);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic cnt_lvl_unused;
    logic gate_fall_unused;

    assign cfg[i] = tc_cfg_t'(cfg_q[i*NIB +: NIB]);

    tc_pin_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .pin_in (cnt_pin[i]),
      .level  (cnt_lvl_unused),
      .fall   (pin_fall[i])
    );

    tc_pin_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .pin_in (gate_pin[i]),
      .level  (gate_lvl[i]),
      .fall   (gate_fall_unused)
    );

    assign cnt_en[i] = run_q[i] & (~cfg[i].gate_en | gate_lvl[i])
                     & (cfg[i].ext_sel ? pin_fall[i] : tick);

    if (i == 0) begin : g_t0
      assign inc[i] = cnt_en[i];
      assign set[i] = wrap[i];
    end else begin : g_tn
      // timer 1 holds in its own split mode; its flag is lent out while timer 0 splits
      assign inc[i] = cnt_en[i] & (cfg[i].mode != MODE_SPLIT);
      assign set[i] = split ? hi_split_wrap : wrap[i];
    end

    tc_step #(.W(BYTE_W), .LB(LOW_BITS)) u_step (
      .mode (cfg[i].mode),
      .inc  (inc[i]),
      .lo   (lo_q[i]),
      .hi   (hi_q[i]),
      .lo_n (lo_n[i]),
      .hi_n (hi_n[i]),
      .wrap (wrap[i])
    );
  end

  // timer 0 high byte as a separate counter in split mode
  assign hi_split_inc  = split & run_q[1] & tick;
  assign hi_split_wrap = hi_split_inc & (&hi_q[0]);
  assign hi_split_n    = hi_split_inc ? hi_q[0] + BYTE_W'(1) : hi_q[0];

  always_comb begin
    for (int i = 0; i < NUM_TMR; i++) begin
      lo_d[i] = lo_n[i];
      hi_d[i] = hi_n[i];
    end
    if (split) hi_d[0] = hi_split_n;
    cfg_d  = cfg_q;
    run_d  = run_q;
    flag_d = flag_q | set;
    if (bus_wen) begin
      unique case (bus_addr)
        ADDR_CTRL: begin
          run_d  = {bus_wdata[6], bus_wdata[4]};
          flag_d = {bus_wdata[7], bus_wdata[5]} | set;
        end
        ADDR_CFG: cfg_d   = bus_wdata;
        ADDR_LO0: lo_d[0] = bus_wdata;
        ADDR_LO1: lo_d[1] = bus_wdata;
        ADDR_HI0: hi_d[0] = bus_wdata;
        ADDR_HI1: hi_d[1] = bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < NUM_TMR; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end
      cfg_q  <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      for (int i = 0; i < NUM_TMR; i++) begin
        lo_q[i] <= lo_d[i];
        hi_q[i] <= hi_d[i];
      end
      cfg_q  <= cfg_d;
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata = {flag_q[1], run_q[1], flag_q[0], run_q[0], 4'h0};
      ADDR_CFG:  bus_rdata = cfg_q;
      ADDR_LO0:  bus_rdata = lo_q[0];
      ADDR_LO1:  bus_rdata = lo_q[1];
      ADDR_HI0:  bus_rdata = hi_q[0];
      ADDR_HI1:  bus_rdata = hi_q[1];
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = flag_q;
endmodule

// File: rtl/tc_pair_chk.sv
module tc_pair_chk
  import tc_pair_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bus_wen,
  input logic [BYTE_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] cfg,
  input logic [BYTE_W-1:0] lo0,
  input logic [BYTE_W-1:0] hi0,
  input logic [BYTE_W-1:0] lo1,
  input logic [BYTE_W-1:0] hi1,
  input logic [1:0]        gate_lvl,
  input logic [1:0]        set,
  input logic [1:0]        flag
);
  logic wr_ctrl, wr_lo0, wr_hi0, wr_lo1, wr_hi1;

  assign wr_ctrl = bus_wen && (bus_addr == ADDR_CTRL);
  assign wr_lo0  = bus_wen && (bus_addr == ADDR_LO0);
  assign wr_hi0  = bus_wen && (bus_addr == ADDR_HI0);
  assign wr_lo1  = bus_wen && (bus_addr == ADDR_LO1);
  assign wr_hi1  = bus_wen && (bus_addr == ADDR_HI1);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3

  AST_RELOAD_HI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1:0] == 2'd2 && !wr_hi0) |=> $stable(hi0)); // R6

  AST_T1_SPLIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[5:4] == 2'd3 && !wr_lo1 && !wr_hi1) |=> ($stable(lo1) && $stable(hi1))); // R11

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[3] && !gate_lvl[0] && !wr_lo0) |=> $stable(lo0)); // R7

  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag[0] && !set[0] && !wr_ctrl) |=> !flag[0]); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[1] && !wr_ctrl) |=> flag[1]); // R9
endmodule

bind tc_pair tc_pair_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .tick     (tick),
  .bus_wen  (bus_wen),
  .bus_addr (bus_addr),
  .cfg      (cfg_q),
  .lo0      (lo_q[0]),
  .hi0      (hi_q[0]),
  .lo1      (lo_q[1]),
  .hi1      (hi_q[1]),
  .gate_lvl (gate_lvl),
  .set      (set),
  .flag     (flag_q)
);

// File: tb/tc_pair_tb.sv
`timescale 1ns/1ps
module tc_pair_tb;
  logic       clk;
  logic       rst_n;
  logic       bus_wen;
  logic [7:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [1:0] cnt_pin;
  logic [1:0] gate_pin;
  logic [1:0] irq;
  int         n_checks;
  int         n_errors;
  logic       done;

  localparam logic [7:0] A_CTRL = 8'h88, A_CFG = 8'h89, A_LO0 = 8'h8A,
                         A_LO1 = 8'h8B, A_HI0 = 8'h8C, A_HI1 = 8'h8D;

  tc_pair u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_pin   (cnt_pin),
    .gate_pin  (gate_pin),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wen   = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(posedge clk);
    #1 bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // start the given run bits, count for exactly 12*k edges, stop keeping flags
  task automatic run_window(input logic [7:0] run_bits, input int k);
    logic [7:0] c;
    wr(A_CTRL, run_bits);
    repeat (12 * k - 1) @(posedge clk);
    @(negedge clk);
    bus_addr = A_CTRL;
    #0.1 c = bus_rdata;
    bus_wen   = 1'b1;
    bus_wdata = c & 8'hA0;
    @(posedge clk);
    #1 bus_wen = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(A_CTRL, v); check("R1", "ctrl", v, 8'h00);
    rd(A_CFG, v);  check("R1", "cfg", v, 8'h00);
    rd(A_LO0, v);  check("R1", "lo0", v, 8'h00);
    rd(A_HI0, v);  check("R1", "hi0", v, 8'h00);
    rd(A_LO1, v);  check("R1", "lo1", v, 8'h00);
    rd(A_HI1, v);  check("R1", "hi1", v, 8'h00);
    check("R1", "irq", {6'd0, irq}, 8'h00);
  endtask

  task automatic t_map;
    logic [7:0] v;
    wr(A_CFG, 8'hA5); rd(A_CFG, v); check("R2", "cfg readback", v, 8'hA5);
    wr(A_LO0, 8'h12); wr(A_LO1, 8'h34); wr(A_HI0, 8'h56); wr(A_HI1, 8'h78);
    rd(A_LO0, v); check("R2", "lo0", v, 8'h12);
    rd(A_LO1, v); check("R2", "lo1", v, 8'h34);
    rd(A_HI0, v); check("R2", "hi0", v, 8'h56);
    rd(A_HI1, v); check("R2", "hi1", v, 8'h78);
    wr(A_CTRL, 8'hAF); rd(A_CTRL, v); check("R2", "ctrl low nibble", v, 8'hA0);
    rd(8'h90, v); check("R2", "unmapped", v, 8'h00);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_tick;
    logic [7:0] v;
    wr(A_CFG, 8'h11);
    wr(A_LO0, 8'h10); wr(A_HI0, 8'h00); wr(A_LO1, 8'h20); wr(A_HI1, 8'h00);
    run_window(8'h50, 5);
    rd(A_LO0, v); check("R3", "lo0 after 60 clocks", v, 8'h15);
    rd(A_LO1, v); check("R3", "lo1 after 60 clocks", v, 8'h25);
  endtask

  task automatic t_mode1;
    logic [7:0] v;
    wr(A_CTRL, 8'h00); wr(A_CFG, 8'h11);
    wr(A_LO0, 8'hFE); wr(A_HI0, 8'hFF);
    run_window(8'h10, 3);
    rd(A_LO0, v); check("R4", "lo0 wrap", v, 8'h01);
    rd(A_HI0, v); check("R4", "hi0 wrap", v, 8'h00);
    rd(A_CTRL, v); check("R4", "flag0", v, 8'h20);
    check("R4", "irq0", {6'd0, irq}, 8'h01);
  endtask

  task automatic t_clear;
    logic [7:0] v;
    wr(A_CTRL, 8'h00);
    rd(A_CTRL, v); check("R9", "flag0 cleared", v, 8'h00);
    check("R9", "irq low", {6'd0, irq}, 8'h00);
  endtask

  task automatic t_mode0;
    logic [7:0] v;
    wr(A_CFG, 8'h00);
    wr(A_LO0, 8'hFE); wr(A_HI0, 8'hFF);
    run_window(8'h10, 3);
    rd(A_LO0, v); check("R5", "lo0 upper bits kept", v, 8'hE1);
    rd(A_HI0, v); check("R5", "hi0 wrap", v, 8'h00);
    rd(A_CTRL, v); check("R5", "flag0", v, 8'h20);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_mode2;
    logic [7:0] v;
    wr(A_CFG, 8'h02);
    wr(A_LO0, 8'hFE); wr(A_HI0, 8'h9C);
    run_window(8'h10, 3);
    rd(A_LO0, v); check("R6", "lo0 reloaded", v, 8'h9D);
    rd(A_HI0, v); check("R6", "hi0 kept", v, 8'h9C);
    rd(A_CTRL, v); check("R6", "flag0", v, 8'h20);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_gate;
    logic [7:0] v;
    gate_pin = 2'b00;
    wr(A_CFG, 8'h09);
    wr(A_LO0, 8'h00); wr(A_HI0, 8'h00);
    repeat (5) @(posedge clk);
    run_window(8'h10, 2);
    rd(A_LO0, v); check("R7", "gate low blocks", v, 8'h00);
    gate_pin = 2'b01;
    repeat (5) @(posedge clk);
    run_window(8'h10, 2);
    rd(A_LO0, v); check("R7", "gate high counts", v, 8'h02);
    gate_pin = 2'b00;
  endtask

  task automatic t_extern;
    logic [7:0] v;
    cnt_pin = 2'b00;
    wr(A_CFG, 8'h51);
    wr(A_LO1, 8'h00); wr(A_HI1, 8'h00);
    wr(A_CTRL, 8'h40);
    for (int p = 0; p < 3; p++) begin
      cnt_pin[1] = 1'b1; repeat (5) @(posedge clk);
      cnt_pin[1] = 1'b0; repeat (5) @(posedge clk);
    end
    rd(A_LO1, v); check("R8", "three falls", v, 8'h03);
    cnt_pin[1] = 1'b1; repeat (30) @(posedge clk);
    rd(A_LO1, v); check("R8", "rise and ticks ignored", v, 8'h03);
    wr(A_CTRL, 8'h00);
    cnt_pin = 2'b00;
  endtask

  task automatic t_split;
    logic [7:0] v;
    wr(A_CFG, 8'h03);
    wr(A_LO0, 8'hFE); wr(A_HI0, 8'hFD);
    run_window(8'h50, 3);
    rd(A_LO0, v); check("R10", "low half", v, 8'h01);
    rd(A_HI0, v); check("R10", "high half", v, 8'h00);
    rd(A_CTRL, v); check("R10", "both flags", v, 8'hA0);
    check("R10", "irq both", {6'd0, irq}, 8'h03);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_t1hold;
    logic [7:0] v;
    wr(A_CFG, 8'h31);
    wr(A_LO1, 8'h44); wr(A_HI1, 8'h55);
    run_window(8'h40, 4);
    rd(A_LO1, v); check("R11", "lo1 held", v, 8'h44);
    rd(A_HI1, v); check("R11", "hi1 held", v, 8'h55);
    rd(A_CTRL, v); check("R11", "no flag1", v, 8'h00);
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    n_checks  = 0;
    n_errors  = 0;
    rst_n     = 1'b0;
    bus_wen   = 1'b0;
    bus_addr  = 8'h00;
    bus_wdata = 8'h00;
    cnt_pin   = 2'b00;
    gate_pin  = 2'b00;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset;
    t_map;
    t_tick;
    t_mode1;
    t_clear;
    t_mode0;
    t_mode2;
    t_gate;
    t_extern;
    t_split;
    t_t1hold;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule